// File: doc/BRIEF.md
# SPI panel register init sequencer

This block brings an LCD panel controller into a known configuration by replaying a fixed list of register writes over a write-only SPI link. After a one-cycle start request it walks its built-in table of 24 register/value pairs. For each pair it sends two separate chip-select framed transactions of three bytes each: first a frame that selects the register, then a frame that carries the 16-bit value.

The serial clock comes from a parameterised divider of the system clock. Bytes go out most significant bit first in SPI mode 0. Chip select stays high for at least one serial clock period between any two frames. When the last frame has closed, the block gives a one-cycle done pulse and raises the panel enable output. The panel enable output stays low from reset and during every replay, so the panel is only switched on once its configuration is complete.

Top module: `panel_init_seq`

## Requirements
- R1: Every frame is exactly 24 bits, sent MSB first in SPI mode 0. MOSI is held steady while SCLK is high, and SCLK is low whenever CS_n is high.
- R2: A register-select frame carries the bytes 0x70, 0x00 and (register number AND 0x7F), in that order.
- R3: A value frame carries the bytes 0x72, the upper byte of the 16-bit value and the lower byte, in that order.
- R4: Each table entry produces a register-select frame followed by its value frame, with CS_n returning high between the two. A replay is exactly 48 frames.
- R5: The entries are sent in this fixed order, written register:value in hex: 01:6300, 02:0200, 03:0177, 04:04C7, 05:FFC0, 06:E806, 0A:4008, 0B:0000, 0D:0030, 0E:2800, 0F:0000, 16:9F80, 17:0A0F, 1E:00C1, 30:0300, 31:0007, 32:0000, 33:0000, 34:0707, 35:0004, 36:0302, 37:0202, 3A:0A0D, 3B:0806.
- R6: Between two consecutive frames of a replay, CS_n stays high for at least 2*HALF_DIV system clock cycles.
- R7: Each SCLK high phase lasts exactly HALF_DIV system clock cycles.
- R8: A start pulse while idle begins a replay, and busy is high from the next cycle. A start pulse while busy is ignored: the replay neither restarts nor repeats.
- R9: Done is a single-cycle pulse issued after the CS_n of the last frame has gone high. Busy falls in the same cycle.
- R10: Panel enable is low while busy. It rises together with the done pulse and stays high until the next accepted start, which clears it.
- R11: In reset, CS_n is high, SCLK is low, and busy, done and panel enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to replay the table |
| busy | output | 1 | High while a replay is in progress |
| done | output | 1 | One-cycle pulse when a replay completes |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_cs_n | output | 1 | Active-low chip select, one assertion per frame |
| panel_enable | output | 1 | Panel power/display enable |

## Verification
Several properties are checked on every cycle: SCLK stays low while chip select is high, MOSI holds while SCLK is high, done never lasts more than one cycle, panel enable stays low while busy and rises only with done, and a start during a replay leaves the table position unchanged. Only the bench scenarios can show the content and order of the 48 frames, the gap length and SCLK high time, the total frame count after an ignored start, and the behaviour of a second replay. The bench rebuilds each expected frame from the table and the frame layout and compares every captured bit pattern against it.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

    localparam int unsigned NUM_WRITES = 24;
    localparam int unsigned IDX_W      = $clog2(NUM_WRITES);
    localparam int unsigned FRAME_BITS = 24;
    localparam int unsigned BIT_CNT_W  = $clog2(FRAME_BITS);
    localparam logic [7:0]  SEL_PREFIX = 8'h70;
    localparam logic [7:0]  VAL_PREFIX = 8'h72;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] data;
    } reg_write_t;

    typedef enum logic [2:0] {
        FR_IDLE, FR_LEAD, FR_HIGH, FR_LOW, FR_GAP
    } frame_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_LAUNCH, SQ_WAIT
    } seq_state_e;

    // Fixed configuration list; the order is significant.
    function automatic reg_write_t table_entry(input logic [IDX_W-1:0] i);
        reg_write_t w;
        case (i)
            5'd0:    w = '{8'h01, 16'h6300};
            5'd1:    w = '{8'h02, 16'h0200};
            5'd2:    w = '{8'h03, 16'h0177};
            5'd3:    w = '{8'h04, 16'h04C7};
            5'd4:    w = '{8'h05, 16'hFFC0};
            5'd5:    w = '{8'h06, 16'hE806};
            5'd6:    w = '{8'h0A, 16'h4008};
            5'd7:    w = '{8'h0B, 16'h0000};
            5'd8:    w = '{8'h0D, 16'h0030};
            5'd9:    w = '{8'h0E, 16'h2800};
            5'd10:   w = '{8'h0F, 16'h0000};
            5'd11:   w = '{8'h16, 16'h9F80};
            5'd12:   w = '{8'h17, 16'h0A0F};
            5'd13:   w = '{8'h1E, 16'h00C1};
            5'd14:   w = '{8'h30, 16'h0300};
            5'd15:   w = '{8'h31, 16'h0007};
            5'd16:   w = '{8'h32, 16'h0000};
            5'd17:   w = '{8'h33, 16'h0000};
            5'd18:   w = '{8'h34, 16'h0707};
            5'd19:   w = '{8'h35, 16'h0004};
            5'd20:   w = '{8'h36, 16'h0302};
            5'd21:   w = '{8'h37, 16'h0202};
            5'd22:   w = '{8'h3A, 16'h0A0D};
            default: w = '{8'h3B, 16'h0806};
        endcase
        return w;
    endfunction

    function automatic logic [FRAME_BITS-1:0] select_frame(input reg_write_t w);
        return {SEL_PREFIX, 8'h00, 1'b0, w.addr[6:0]};
    endfunction

    function automatic logic [FRAME_BITS-1:0] value_frame(input reg_write_t w);
        return {VAL_PREFIX, w.data};
    endfunction

endpackage

// File: rtl/panel_half_timer.sv
module panel_half_timer #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear || cnt_q == LAST) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST) && !clear;
endmodule

// File: rtl/panel_spi_frame_tx.sv
module panel_spi_frame_tx
    import panel_init_pkg::*;
#(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_start,
    input  logic [FRAME_BITS-1:0] frame_data,
    output logic                  frame_done,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  cs_n
);
    frame_state_e          st_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [BIT_CNT_W-1:0]  bit_q;
    logic                  gap_q;
    logic                  tick;

    panel_half_timer #(.HALF_DIV(HALF_DIV)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .clear (st_q == FR_IDLE),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= FR_IDLE;
            shreg_q    <= '0;
            bit_q      <= '0;
            gap_q      <= 1'b0;
            sclk       <= 1'b0;
            cs_n       <= 1'b1;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (st_q)
                FR_IDLE: if (frame_start) begin
                    shreg_q <= frame_data;
                    cs_n    <= 1'b0;
                    st_q    <= FR_LEAD;
                end
                FR_LEAD: if (tick) begin
                    sclk  <= 1'b1;
                    bit_q <= '0;
                    st_q  <= FR_HIGH;
                end
                FR_HIGH: if (tick) begin
                    sclk <= 1'b0;
                    if (bit_q == BIT_CNT_W'(FRAME_BITS - 1)) begin
                        cs_n  <= 1'b1;
                        gap_q <= 1'b0;
                        st_q  <= FR_GAP;
                    end else begin
                        shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
                        st_q    <= FR_LOW;
                    end
                end
                FR_LOW: if (tick) begin
                    sclk  <= 1'b1;
                    bit_q <= bit_q + 1'b1;
                    st_q  <= FR_HIGH;
                end
                FR_GAP: if (tick) begin
                    gap_q <= 1'b1;
                    if (gap_q) begin
                        frame_done <= 1'b1;
                        st_q       <= FR_IDLE;
                    end
                end
                default: st_q <= FR_IDLE;
            endcase
        end
    end

    assign mosi = shreg_q[FRAME_BITS-1];

    // R1
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    // R1
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/panel_init_ctrl.sv
module panel_init_ctrl
    import panel_init_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  frame_done,
    output logic                  frame_start,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic                  busy,
    output logic                  done,
    output logic                  panel_enable
);
    seq_state_e       st_q;
    logic [IDX_W-1:0] idx_q;
    logic             value_phase_q;
    reg_write_t       entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= SQ_IDLE;
            idx_q         <= '0;
            value_phase_q <= 1'b0;
            busy          <= 1'b0;
            done          <= 1'b0;
            panel_enable  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                SQ_IDLE: if (start) begin
                    busy          <= 1'b1;
                    panel_enable  <= 1'b0;
                    idx_q         <= '0;
                    value_phase_q <= 1'b0;
                    st_q          <= SQ_LAUNCH;
                end
                SQ_LAUNCH: st_q <= SQ_WAIT;
                SQ_WAIT: if (frame_done) begin
                    if (!value_phase_q) begin
                        value_phase_q <= 1'b1;
                        st_q          <= SQ_LAUNCH;
                    end else if (idx_q == IDX_W'(NUM_WRITES - 1)) begin
                        busy         <= 1'b0;
                        done         <= 1'b1;
                        panel_enable <= 1'b1;
                        st_q         <= SQ_IDLE;
                    end else begin
                        idx_q         <= idx_q + 1'b1;
                        value_phase_q <= 1'b0;
                        st_q          <= SQ_LAUNCH;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        entry       = table_entry(idx_q);
        frame_start = (st_q == SQ_LAUNCH);
        frame_data  = value_phase_q ? value_frame(entry) : select_frame(entry);
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    enable_low_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !panel_enable);
    // R10
    enable_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(panel_enable) |-> done);
    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !frame_done) |=> $stable(idx_q));
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import panel_init_pkg::*;
#(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic spi_sclk,
    output logic spi_mosi,
    output logic spi_cs_n,
    output logic panel_enable
);
    logic                  frame_start;
    logic                  frame_done;
    logic [FRAME_BITS-1:0] frame_data;

    panel_init_ctrl ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .frame_done   (frame_done),
        .frame_start  (frame_start),
        .frame_data   (frame_data),
        .busy         (busy),
        .done         (done),
        .panel_enable (panel_enable)
    );

    panel_spi_frame_tx #(.HALF_DIV(HALF_DIV)) tx_i (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_data  (frame_data),
        .frame_done  (frame_done),
        .sclk        (spi_sclk),
        .mosi        (spi_mosi),
        .cs_n        (spi_cs_n)
    );

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (spi_cs_n && !spi_sclk && !busy && !done && !panel_enable));
endmodule

// File: tb/panel_init_seq_tb_top.sv
module panel_init_seq_tb_top;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, sclk, mosi, cs_n, pen;

    always #10 clk = ~clk;

    panel_init_seq #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n), .panel_enable(pen)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected table, written independently
    logic [7:0]  e_addr [24];
    logic [15:0] e_data [24];
    initial begin
        e_addr = '{8'h01,8'h02,8'h03,8'h04,8'h05,8'h06,8'h0A,8'h0B,8'h0D,8'h0E,8'h0F,8'h16,
                   8'h17,8'h1E,8'h30,8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h3A,8'h3B};
        e_data = '{16'h6300,16'h0200,16'h0177,16'h04C7,16'hFFC0,16'hE806,16'h4008,16'h0000,
                   16'h0030,16'h2800,16'h0000,16'h9F80,16'h0A0F,16'h00C1,16'h0300,16'h0007,
                   16'h0000,16'h0000,16'h0707,16'h0004,16'h0302,16'h0202,16'h0A0D,16'h0806};
    end

    // frame capture
    logic [23:0] frames [100];
    int          fbits  [100];
    int          fcnt = 0;
    logic [23:0] cap = '0;
    int          nb = 0;
    always @(negedge cs_n) begin cap = '0; nb = 0; end
    always @(posedge sclk) if (!cs_n) begin cap = {cap[22:0], mosi}; nb++; end
    always @(posedge cs_n) if (!rst && fcnt < 100) begin
        frames[fcnt] = cap; fbits[fcnt] = nb; fcnt++;
    end

    // timing monitors
    int hi_run = 0, hi_min = 1000, hi_max = 0;
    int gap_run = 0, gap_min = 1000, run_frames = 0;
    int sclk_when_idle = 0, done_cnt = 0, done_long = 0;
    logic prev_cs = 1'b1, prev_done = 1'b0;
    always @(negedge clk) if (!rst) begin
        if (sclk) hi_run++;
        else if (hi_run > 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (!cs_n && prev_cs) begin
            if (run_frames > 0 && gap_run < gap_min) gap_min = gap_run;
            run_frames++;
        end
        if (cs_n) gap_run++; else gap_run = 0;
        if (cs_n && sclk) sclk_when_idle++;
        if (done) begin
            done_cnt++; run_frames = 0;
            if (prev_done) done_long++;
        end
        prev_cs = cs_n; prev_done = done;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        check(done, "R9 done seen", 32'(done), 1);
    endtask

    task automatic check_frames(input int base);
        for (int k = 0; k < 24; k++) begin
            check(frames[base+2*k] == {8'h70, 8'h00, 1'b0, e_addr[k][6:0]},
                  $sformatf("R2 R5 select frame %0d", k), 32'(frames[base+2*k]),
                  32'({8'h70, 8'h00, 1'b0, e_addr[k][6:0]}));
            check(frames[base+2*k+1] == {8'h72, e_data[k]},
                  $sformatf("R3 R5 value frame %0d", k), 32'(frames[base+2*k+1]),
                  32'({8'h72, e_data[k]}));
            check(fbits[base+2*k] == 24 && fbits[base+2*k+1] == 24,
                  $sformatf("R1 bit count entry %0d", k), 32'(fbits[base+2*k+1]), 24);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R11 reset state
        check(cs_n == 1'b1, "R11 cs_n", 32'(cs_n), 1);
        check(sclk == 1'b0, "R11 sclk", 32'(sclk), 0);
        check(!busy && !done, "R11 busy/done", {busy, done}, 0);
        check(pen == 1'b0, "R11 panel_enable", 32'(pen), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && cs_n, "R8 idle without start", {busy, cs_n}, 1);

        // first replay, with an ignored start in the middle
        pulse_start();
        check(busy == 1'b1, "R8 busy after start", 32'(busy), 1);
        check(pen == 1'b0, "R10 enable low while busy", 32'(pen), 0);
        repeat (800) @(negedge clk);
        check(fcnt > 0 && fcnt < 48, "R8 mid-run frame count", fcnt, 8);
        pulse_start();
        wait_done();
        check(!busy, "R9 busy falls with done", 32'(busy), 0);
        check(pen, "R10 enable rises with done", 32'(pen), 1);
        check(cs_n, "R9 cs_n high at done", 32'(cs_n), 1);
        @(negedge clk);
        check(!done, "R9 done one cycle", 32'(done), 0);
        repeat (300) @(negedge clk);
        check(fcnt == 48, "R4 R8 frames per replay", fcnt, 48);
        check(!busy && pen, "R8 R10 no restart after ignored start", {busy, pen}, 1);
        check_frames(0);
        check(gap_min >= 2*HALF, "R6 min chip-select gap", gap_min, 2*HALF);
        check(hi_min == HALF && hi_max == HALF, "R7 sclk high phase", {hi_min[15:0], hi_max[15:0]}, {16'(HALF), 16'(HALF)});
        check(sclk_when_idle == 0, "R1 sclk low while deselected", sclk_when_idle, 0);

        // second replay: enable drops, same frames again
        pulse_start();
        check(pen == 1'b0 && busy, "R10 enable cleared by new start", {pen, busy}, 1);
        wait_done();
        @(negedge clk);
        repeat (50) @(negedge clk);
        check(fcnt == 96, "R4 frames after second replay", fcnt, 96);
        check_frames(48);
        check(done_cnt == 2 && done_long == 0, "R9 done pulse count", {done_cnt[15:0], done_long[15:0]}, 32'h00020000);
        check(pen, "R10 enable held after replay", 32'(pen), 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule